// File: doc/BRIEF.md
# Bidirectional Current DAC Control Registers with Two-Wire Serial Slave

This block holds the setpoints for a bank of two or four bidirectional current DAC channels. A host writes and reads them over an I2C bus. The block runs on a fast system clock. It oversamples the bus clock and data lines, and it pulls the data line low through an open-drain enable. Two strap inputs pick which of four bus addresses the block answers to, so up to four such blocks can share one bus.

Each channel register is one byte in sign-magnitude form. The top bit selects the current direction and the low seven bits give the magnitude. The block splits this byte into a sink enable, a source enable and a 7-bit magnitude, which drive the analog stage directly. A magnitude of zero switches the channel off whatever the direction bit says. The `NCH` parameter builds the block with either two or four channels.

Top module: `bdac_i2c_regs`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {strap_i[1], strap_i[0], 1, 0, 0, 0, 0}. Bit 0 of that byte is the direction: 0 for a write, 1 for a read. With strap_i = 01 the write byte is 60h, and with strap_i = 10 it is A0h.
- R2: Channel n (n = 0 .. NCH-1) is stored at register address F8h + n. In each register, bit 7 is the direction (0 = sink, 1 = source) and bits 6:0 are the magnitude. With NCH = 2 only F8h and F9h exist.
- R3: For every channel, sink_en = ~dir & (mag != 0), source_en = dir & (mag != 0), and the channel's magnitude output equals the stored magnitude. A magnitude of zero clears both enables.
- R4: After reset every register is 00h, so every output is zero.
- R5: The write sequence is START, address byte with bit 0 = 0, register-address byte, data byte, STOP. The block pulls SDA low in the ninth clock after each byte it accepts, and the addressed register takes the data byte. Register outputs change only while SCL is low.
- R6: A read is a pointer write, then a repeated START, then the address byte with bit 0 = 1. The block then shifts the selected register out MSB first. When the host sends a NACK in the ninth bit, the block releases SDA.
- R7: After an address byte that does not match, the block never drives SDA and ignores the bus until the next START.
- R8: The block changes its SDA drive only while SCL is low.
- R9: SCL and SDA pass through a two-flop synchronizer and a 3-sample filter. A pulse shorter than three system clocks has no effect. The block works for any SCL period of at least 20 system clocks.
- R10: When the register pointer holds an address outside the implemented set, the block does not acknowledge a data byte and no register changes. A read at that pointer returns 00h.
- R11: The register pointer keeps its value across transactions and never increments. A read without a new pointer write returns the last addressed register, and every further byte of a multi-byte read returns the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| strap_i | input | 2 | Address strap pins; bit 1 is the top address bit |
| sda_oe | output | 1 | Pulls SDA low when 1 (open-drain drive) |
| sink_en | output | NCH | Per-channel sink enable |
| source_en | output | NCH | Per-channel source enable |
| mag_o | output | 7*NCH | Per-channel magnitude; channel n in bits 7n+6:7n |

## Verification
The bench puts two instances on one wired-AND bus. One is built with four channels and strapped to 60h. The other is built with two channels and strapped to A0h. The four-channel instance exercises all four registers and every sign and zero case. Because the two instances share the bus, each transaction aimed at one of them shows whether the other one stays silent. On the two-channel instance, FAh is unimplemented, which exposes the data-byte NACK and the 00h read path. The bench also varies the SCL period and adds short pulses on SCL to exercise the filter.

// File: rtl/bdac_pkg.sv
package bdac_pkg;

    localparam int MAG_W = 7;
    localparam int BYTE_W = 8;
    // low five bits of the 7-bit bus address, below the two strap bits
    localparam logic [4:0] ADDR_FIXED = 5'b10000;
    // upper six bits of every channel register address
    localparam logic [5:0] WINDOW_TAG = 6'b111110;

    typedef struct packed {
        logic             dir;
        logic [MAG_W-1:0] mag;
    } chan_set_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_WDATA,
        PH_ACK,
        PH_TX,
        PH_TXACK,
        PH_SKIP
    } phase_t;

    function automatic logic ptr_hit(input logic [BYTE_W-1:0] p, input int nch);
        return (p[7:2] == WINDOW_TAG) && (int'(p[1:0]) < nch);
    endfunction

endpackage

// File: rtl/bdac_line_filter.sv
module bdac_line_filter #(
    parameter int LINES = 2,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] clean
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [1:0]       sync;
        logic [DEPTH-1:0] hist;
        logic             q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync <= '1;
                hist <= '1;
                q    <= 1'b1;
            end else begin
                sync <= {sync[0], raw[i]};
                hist <= {hist[DEPTH-2:0], sync[1]};
                // the output follows only once DEPTH samples agree
                if (&hist)
                    q <= 1'b1;
                else if (~|hist)
                    q <= 1'b0;
            end
        end

        assign clean[i] = q;
    end

endmodule

// File: rtl/bdac_i2c_engine.sv
module bdac_i2c_engine
    import bdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl,
    input  logic              sda,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ptr
);

    logic scl_q, sda_q;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    phase_t            ph, after_ack;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] sr;
    logic [6:0]        tx_rest;
    logic              host_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign bus_start = scl & scl_q & sda_q & ~sda;
    assign bus_stop  = scl & scl_q & ~sda_q & sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            after_ack <= PH_IDLE;
            cnt       <= '0;
            sr        <= '0;
            tx_rest   <= '0;
            host_ack  <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            ptr       <= '0;
        end else begin
            wr_en <= 1'b0;
            if (bus_start) begin
                ph     <= PH_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (bus_stop) begin
                ph     <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (ph)
                    PH_ADDR, PH_PTR, PH_WDATA: begin
                        if (scl_rise) begin
                            sr  <= {sr[6:0], sda};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (ph == PH_ADDR) begin
                                if (sr[7:1] == {strap, ADDR_FIXED}) begin
                                    sda_oe    <= 1'b1;
                                    ph        <= PH_ACK;
                                    after_ack <= sr[0] ? PH_TX : PH_PTR;
                                end else begin
                                    ph <= PH_SKIP;
                                end
                            end else if (ph == PH_PTR) begin
                                ptr       <= sr;
                                sda_oe    <= 1'b1;
                                ph        <= PH_ACK;
                                after_ack <= PH_WDATA;
                            end else if (ptr_hit(ptr, NCH)) begin
                                wr_en     <= 1'b1;
                                wr_data   <= sr;
                                sda_oe    <= 1'b1;
                                ph        <= PH_ACK;
                                after_ack <= PH_WDATA;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (scl_fall) begin
                            ph  <= after_ack;
                            cnt <= '0;
                            if (after_ack == PH_TX) begin
                                tx_rest <= rd_data[6:0];
                                sda_oe  <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                ph     <= PH_TXACK;
                                cnt    <= '0;
                            end else begin
                                sda_oe  <= ~tx_rest[6];
                                tx_rest <= {tx_rest[5:0], 1'b0};
                            end
                        end
                    end
                    PH_TXACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                tx_rest <= rd_data[6:0];
                                sda_oe  <= ~rd_data[7];
                                ph      <= PH_TX;
                                cnt     <= '0;
                            end else begin
                                ph <= PH_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/bdac_chan_bank.sv
module bdac_chan_bank
    import bdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [BYTE_W-1:0]    ptr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NCH-1:0]       sink_en,
    output logic [NCH-1:0]       source_en,
    output logic [NCH*MAG_W-1:0] mag_o
);

    chan_set_t regs [NCH];
    logic      hit;

    assign hit = ptr_hit(ptr, NCH);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic live;

        always_ff @(posedge clk) begin
            if (rst)
                regs[c] <= '0;
            else if (wr_en && hit && ptr[1:0] == 2'(c))
                regs[c] <= chan_set_t'(wr_data);
        end

        assign live                  = |regs[c].mag;
        assign sink_en[c]            = ~regs[c].dir & live;
        assign source_en[c]          = regs[c].dir & live;
        assign mag_o[c*MAG_W +: MAG_W] = regs[c].mag;
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (hit && ptr[1:0] == 2'(c))
                rd_data = regs[c];
        end
    end

endmodule

// File: rtl/bdac_i2c_regs.sv
module bdac_i2c_regs
    import bdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [1:0]           strap_i,
    output logic                 sda_oe,
    output logic [NCH-1:0]       sink_en,
    output logic [NCH-1:0]       source_en,
    output logic [NCH*MAG_W-1:0] mag_o
);

    logic [1:0]        line_clean;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, ptr, rd_data;

    bdac_line_filter #(.LINES(2), .DEPTH(3)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .raw   ({scl_i, sda_i}),
        .clean (line_clean)
    );

    bdac_i2c_engine #(.NCH(NCH)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .scl     (line_clean[1]),
        .sda     (line_clean[0]),
        .strap   (strap_i),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ptr     (ptr)
    );

    bdac_chan_bank #(.NCH(NCH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .rd_data   (rd_data),
        .sink_en   (sink_en),
        .source_en (source_en),
        .mag_o     (mag_o)
    );

endmodule

// File: rtl/bdac_i2c_regs_chk.sv
module bdac_i2c_regs_chk #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_i,
    input logic             sda_oe,
    input logic [NCH-1:0]   sink_en,
    input logic [NCH-1:0]   source_en,
    input logic [NCH*7-1:0] mag_o
);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        AST_ZERO_MAG_OFF: assert property (@(posedge clk) disable iff (rst)
            (mag_o[c*7 +: 7] == 7'd0) |-> (!sink_en[c] && !source_en[c])); // R3
        AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
            (mag_o[c*7 +: 7] != 7'd0) |-> (sink_en[c] ^ source_en[c])); // R3
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (mag_o == '0 && sink_en == '0 && source_en == '0)); // R4

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i); // R8

    AST_UPDATE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(mag_o) |-> !scl_i); // R5

endmodule

bind bdac_i2c_regs bdac_i2c_regs_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .sink_en   (sink_en),
    .source_en (source_en),
    .mag_o     (mag_o)
);

// File: tb/sim_bdac_i2c_regs.sv
module sim_bdac_i2c_regs;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic oe0, oe1;
    wire  sda_bus = m_sda & ~oe0 & ~oe1;

    logic [3:0]  snk0, src0;
    logic [27:0] mag0;
    logic [1:0]  snk1, src1;
    logic [13:0] mag1;

    bdac_i2c_regs #(.NCH(4)) u0 (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(2'b01),
        .sda_oe(oe0), .sink_en(snk0), .source_en(src0), .mag_o(mag0)
    );

    bdac_i2c_regs #(.NCH(2)) u1 (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(2'b10),
        .sda_oe(oe1), .sink_en(snk1), .source_en(src1), .mag_o(mag1)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    int   Q = 10;
    logic glitch_en = 1'b0;
    logic seen0 = 1'b0;
    logic seen1 = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            if (oe0) seen0 = 1'b1;
            if (oe1) seen1 = 1'b1;
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic wbit(input logic b);
        m_sda = b;
        if (glitch_en) begin
            tick(Q / 2);
            m_scl = 1'b1; tick(2);
            m_scl = 1'b0; tick(Q - Q / 2 - 2);
        end else begin
            tick(Q);
        end
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_bus;  tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(nack);
    endtask

    task automatic reg_write(input logic [7:0] aw, input logic [7:0] p, input logic [7:0] d,
                             output logic [2:0] acks);
        bus_start();
        wbyte(aw, acks[2]);
        wbyte(p, acks[1]);
        wbyte(d, acks[0]);
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] aw, input logic [7:0] p, input logic set_ptr,
                            input logic two, output logic [7:0] d0, output logic [7:0] d1);
        logic a;
        bus_start();
        if (set_ptr) begin
            wbyte(aw, a);
            wbyte(p, a);
            bus_rstart();
        end
        wbyte(aw | 8'h01, a);
        rbyte(d0, ~two);
        d1 = 8'h00;
        if (two) rbyte(d1, 1'b1);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R4 u0 magnitudes", 32'(mag0), 32'h0);
        chk("R4 u0 enables", {snk0, src0}, 32'h0);
        chk("R4 u1 outputs", {mag1, snk1, src1}, 32'h0);
        chk("R4 sda released", {oe0, oe1}, 32'h0);
    endtask

    task automatic t_write_source();
        logic [2:0] a;
        seen1 = 1'b0;
        reg_write(8'h60, 8'hF8, 8'h85, a);
        chk("R5 R1 acks on write", a, 3'b111);
        chk("R3 ch0 source", {snk0[0], src0[0]}, 2'b01);
        chk("R2 ch0 magnitude", mag0[6:0], 7'h05);
        chk("R7 other address silent", seen1, 1'b0);
    endtask

    task automatic t_sign_cases();
        logic [2:0] a;
        reg_write(8'h60, 8'hF9, 8'h23, a);
        chk("R3 ch1 sink", {snk0[1], src0[1], mag0[13:7]}, {2'b10, 7'h23});
        reg_write(8'h60, 8'hFA, 8'h80, a);
        chk("R3 zero magnitude source off", {snk0[2], src0[2], mag0[20:14]}, 9'h0);
        reg_write(8'h60, 8'hFB, 8'h7F, a);
        chk("R2 ch3 full sink", {snk0[3], src0[3], mag0[27:21]}, {2'b10, 7'h7F});
        chk("R2 ch0 untouched", mag0[6:0], 7'h05);
    endtask

    task automatic t_readback();
        logic [7:0] d0, d1;
        reg_read(8'h60, 8'hF9, 1'b1, 1'b0, d0, d1);
        chk("R6 read F9h", d0, 8'h23);
        chk("R6 sda free after nack", oe0, 1'b0);
        reg_read(8'h60, 8'hF8, 1'b1, 1'b0, d0, d1);
        chk("R6 read F8h", d0, 8'h85);
    endtask

    task automatic t_mismatch();
        logic [2:0] a;
        seen0 = 1'b0; seen1 = 1'b0;
        reg_write(8'h20, 8'hF8, 8'h00, a);
        chk("R7 no ack", a[2], 1'b0);
        chk("R7 no drive", {seen0, seen1}, 2'b00);
        chk("R7 ch0 unchanged", {src0[0], mag0[6:0]}, {1'b1, 7'h05});
    endtask

    task automatic t_unimpl();
        logic [2:0] a;
        logic [7:0] d0, d1;
        reg_write(8'hA0, 8'hFA, 8'h55, a);
        chk("R10 data nack two-channel", a, 3'b110);
        chk("R10 u1 unchanged", {mag1, snk1, src1}, 32'h0);
        reg_read(8'hA0, 8'hFA, 1'b1, 1'b0, d0, d1);
        chk("R10 read unimplemented", d0, 8'h00);
        reg_write(8'hA0, 8'hF8, 8'h81, a);
        chk("R2 u1 ch0 write", {a, snk1[0], src1[0], mag1[6:0]}, {3'b111, 2'b01, 7'h01});
        reg_write(8'h60, 8'hF0, 8'h11, a);
        chk("R10 u0 outside window", {a, mag0}, {3'b110, 7'h7F, 7'h00, 7'h23, 7'h05});
    endtask

    task automatic t_pointer();
        logic [2:0] a;
        logic [7:0] d0, d1;
        reg_write(8'h60, 8'hF9, 8'h3C, a);
        reg_read(8'h60, 8'h00, 1'b0, 1'b0, d0, d1);
        chk("R11 pointer kept", d0, 8'h3C);
        reg_read(8'h60, 8'h00, 1'b0, 1'b1, d0, d1);
        chk("R11 no increment", {d0, d1}, 16'h3C3C);
    endtask

    task automatic t_glitch();
        logic [2:0] a;
        glitch_en = 1'b1;
        reg_write(8'h60, 8'hFB, 8'h5A, a);
        glitch_en = 1'b0;
        chk("R9 short scl pulses ignored", {a, mag0[27:21]}, {3'b111, 7'h5A});
    endtask

    task automatic t_slow();
        logic [2:0] a;
        logic [7:0] d0, d1;
        Q = 40;
        reg_write(8'h60, 8'hF8, 8'h00, a);
        chk("R9 slow rate write", {a, snk0[0], src0[0], mag0[6:0]}, {3'b111, 9'h0});
        reg_read(8'h60, 8'hFB, 1'b1, 1'b0, d0, d1);
        chk("R9 slow rate read", d0, 8'h5A);
        Q = 10;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(10);
        t_reset();
        t_write_source();
        t_sign_cases();
        t_readback();
        t_mismatch();
        t_unimpl();
        t_pointer();
        t_glitch();
        t_slow();
        finish_run();
    end

endmodule